// File: doc/BRIEF.md
# PHY Management Serial Master

This block is a management-bus master that carries single register accesses from a host to an external PHY. The host reaches it through a small 32-bit register port that holds two words: a control word and a transaction word. The control word turns the management clock on and sets its divider. The transaction word carries the PHY address, the register address, the direction and the data. Setting its start bit launches one clause-22 frame. The bit clears itself when the frame ends.

The frame is serialised onto the data pin, most significant bit first. It consists of a 32-bit preamble of ones, the start code 01, an opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround, and 16 data bits. The master drives the data pin only on falling edges of the management clock and samples it on rising edges. During a read it releases the pin from the turnaround onward. It records whether the PHY pulled the second turnaround bit low and then captures the 16 returned bits.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the control word reads with bit 31 (idle) = 1, bit 30 (enable) = 0 and the divider = DIV_RESET. The transaction word reads 0. `mdc` and `mdio_oe` are low.
- R2: Register index 0 is the control word. Bit 30 is the writable enable and bits DIV_W-1:0 are the divider. Bit 31 is read-only, and a write to it has no effect. Register index 1 is the transaction word. The port returns the addressed word one cycle after `reg_addr` is presented.
- R3: While a frame runs with enable set, `mdc` has a period of exactly 2×(divider+1) system clocks. It is low whenever no frame is running.
- R4: A write frame drives 64 bits on `mdio_o` with `mdio_oe` high throughout. The bits are 32 ones, 01, 01, the PHY address, the register address, 10, and then the 16 data bits, MSB first.
- R5: A read frame drives 32 ones, 01, 10, the PHY address and the register address (46 bits). `mdio_oe` is low for bits 46 to 63.
- R6: `mdio_o` changes only in the cycle in which `mdc` falls. `mdio_oe` drops only in such a cycle.
- R7: The transaction word holds bit 31 = 1 (busy) from launch until the 64th `mdc` falling edge, then clears it by itself. Exactly 64 rising edges occur per frame.
- R8: After a read, bit 29 of the transaction word is 1 only if the PHY held the data line low on the second turnaround bit. When bit 29 is 1, bits 15:0 hold the 16 bits sampled on the rising edges. After a write, bit 29 is 0 and bits 15:0 keep the written data.
- R9: A write to the transaction word while bit 31 is set has no effect. The running frame is unchanged, the stored fields are unchanged, and no second frame follows.
- R10: Bit 31 of the control word reads as the inverse of the busy bit of the transaction word.
- R11: While enable is 0, `mdc` is held, so a launched frame waits with busy set. It proceeds when enable is set again.
- R12: The transaction word is laid out as follows: bit 30 = write (1) or read (0), bits 25:21 = register address, bits 20:16 = PHY address, bits 15:0 = data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index (0 control, 1 transaction) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The assertions take for granted that the host writes to the transaction word only through the register port. They also assume the data pin input follows the bus resolution: the driven value while `mdio_oe` is high, and a pulled-up line or the PHY's value otherwise. The bench meets this by modelling the line as the resolution of the master's output, a pull-up, and a PHY model. The PHY model drives only from the second turnaround bit of an acknowledged read onward. Divider values are swept over a small range. The host lowers enable only while no frame is in flight, except in the one test that checks that a frame waits.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DRIVE_BITS = PRE_BITS + 2 + 2 + 5 + 5;   // bits the master owns on a read
  localparam int ACK_POS    = DRIVE_BITS + 1;             // second turnaround bit
  localparam int DATA_POS   = DRIVE_BITS + 2;             // first data bit

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] TA_WR    = 2'b10;

  localparam int BUSY_BIT = 31;
  localparam int DIR_BIT  = 30;
  localparam int ACK_BIT  = 29;
  localparam int IDLE_BIT = 31;
  localparam int EN_BIT   = 30;
endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  always_comb begin
    tick     = busy && en && (cnt == div);
    rise_stb = tick && !mdc;
    fall_stb = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (en) begin
      if (cnt == div) begin
        cnt <= '0;
        mdc <= !mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_seq.sv
module mdio_mgmt_seq
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_in,
  output logic        busy,
  output logic        done,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        ack,
  output logic [15:0] rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] DRV_LAST  = IDX_W'(DRIVE_BITS - 1);
  localparam logic [IDX_W-1:0] ACK_IDX   = IDX_W'(ACK_POS);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_POS);

  logic [FRAME_BITS-1:0] frame_w;
  logic [FRAME_BITS-2:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic                  wr_q;

  always_comb begin
    frame_w = {{PRE_BITS{1'b1}}, SOF_CODE, (is_wr ? OP_WR : OP_RD), phy, regad,
               (is_wr ? TA_WR : 2'b11), (is_wr ? wdata : 16'hFFFF)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
      ack      <= 1'b0;
      rdata    <= '0;
      shreg    <= '1;
      idx      <= '0;
      wr_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          wr_q     <= is_wr;
          shreg    <= frame_w[FRAME_BITS-2:0];
          idx      <= '0;
          mdio_out <= frame_w[FRAME_BITS-1];
          mdio_oe  <= 1'b1;
          ack      <= 1'b0;
        end
      end else begin
        if (fall_stb) begin
          if (idx == LAST_IDX) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b1;
          end else begin
            idx      <= idx + 1'b1;
            mdio_out <= shreg[FRAME_BITS-2];
            shreg    <= {shreg[FRAME_BITS-3:0], 1'b1};
            mdio_oe  <= wr_q || (idx < DRV_LAST);
          end
        end
        if (rise_stb && !wr_q) begin
          if (idx == ACK_IDX) ack <= !mdio_in;
          if (idx >= DATA_IDX) rdata <= {rdata[14:0], mdio_in};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int              DIV_W     = 8,
  parameter int              ADDR_W    = 2,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] IDX_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX_USER = ADDR_W'(1);
  localparam int               PAD_W    = 30 - DIV_W;

  logic             ctrl_en;
  logic [DIV_W-1:0] ctrl_div;
  logic             u_wr, u_ack;
  logic [4:0]       u_reg, u_phy;
  logic [15:0]      u_data;

  logic seq_busy, seq_done, seq_ack, rise_stb, fall_stb;
  logic [15:0] seq_rdata;
  logic wr_ctrl, wr_user, launch;

  always_comb begin
    wr_ctrl = reg_wr_en && (reg_addr == IDX_CTRL);
    wr_user = reg_wr_en && (reg_addr == IDX_USER) && !seq_busy;
    launch  = wr_user && reg_wdata[BUSY_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_div <= DIV_RESET;
      u_wr     <= 1'b0;
      u_ack    <= 1'b0;
      u_reg    <= '0;
      u_phy    <= '0;
      u_data   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= reg_wdata[EN_BIT];
        ctrl_div <= reg_wdata[DIV_W-1:0];
      end
      if (wr_user) begin
        u_wr   <= reg_wdata[DIR_BIT];
        u_reg  <= reg_wdata[25:21];
        u_phy  <= reg_wdata[20:16];
        u_data <= reg_wdata[15:0];
        if (launch) u_ack <= 1'b0;
      end
      if (seq_done) begin
        u_ack <= seq_ack && !u_wr;
        if (!u_wr) u_data <= seq_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        IDX_CTRL: reg_rdata <= {!seq_busy, ctrl_en, {PAD_W{1'b0}}, ctrl_div};
        IDX_USER: reg_rdata <= {seq_busy, u_wr, u_ack, 3'b000, u_reg, u_phy, u_data};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  mdio_mgmt_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
    .clk(clk), .rst(rst), .busy(seq_busy), .en(ctrl_en), .div(ctrl_div),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_mgmt_seq seq_i (
    .clk(clk), .rst(rst), .start(launch), .is_wr(reg_wdata[DIR_BIT]),
    .phy(reg_wdata[20:16]), .regad(reg_wdata[25:21]), .wdata(reg_wdata[15:0]),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_in(mdio_i),
    .busy(seq_busy), .done(seq_done), .mdio_out(mdio_o), .mdio_oe(mdio_oe),
    .ack(seq_ack), .rdata(seq_rdata)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       en,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       user_wr,
  input logic [4:0] u_phy,
  input logic [4:0] u_reg
);
  assert_mdc_low_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_oe_off_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  assert_out_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));

  assert_oe_drop_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> $fell(mdc));

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && user_wr) |=> ($stable(u_phy) && $stable(u_reg)));

  assert_mdc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!en && busy) |=> $stable(mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk chk_i (
  .clk(clk), .rst(rst), .busy(seq_busy), .en(ctrl_en), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .user_wr(reg_wr_en && (reg_addr == IDX_USER)),
  .u_phy(u_phy), .u_reg(u_reg)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int ADDR_W     = 2;
  localparam logic [DIV_W-1:0] DIV_RESET = 8'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;

  // PHY model and line observer
  int          phy_idx = 0;
  logic        phy_rd = 1'b0, phy_ack_en = 1'b0;
  logic [15:0] phy_rdata = '0;
  logic [63:0] cap = '0;
  int          oe_bad = 0, fall_bad = 0, rise0 = 0, rise1 = 0, cyc = 0;
  logic        mdc_q = 1'b0, mdo_q = 1'b1;
  logic        phy_drv, phy_bit;

  always_comb begin
    phy_drv = phy_rd && phy_ack_en && (phy_idx >= 47) && (phy_idx <= 63);
    if (phy_idx == 47) phy_bit = 1'b0;
    else if (phy_idx >= 48 && phy_idx <= 63) phy_bit = phy_rdata[63 - phy_idx];
    else phy_bit = 1'b1;
    mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);
  end

  always #(CLK_PERIOD/2) clk = !clk;

  mdio_mgmt_ctrl #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DIV_RESET(DIV_RESET)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdio_o != mdo_q && !(!mdc && mdc_q)) fall_bad = fall_bad + 1;
    if (mdc && !mdc_q) begin
      if (phy_idx < 64) cap[63 - phy_idx] = mdio_i;
      if (phy_idx == 0) rise0 = cyc;
      if (phy_idx == 1) rise1 = cyc;
      if (phy_rd && phy_idx >= 46 && mdio_oe) oe_bad = oe_bad + 1;
      if (!phy_rd && !mdio_oe) oe_bad = oe_bad + 1;
      phy_idx = phy_idx + 1;
    end
    mdc_q = mdc;
    mdo_q = mdio_o;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(1, v);
      if (!v[31]) break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] d, input bit ack_en);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : (ack_en ? 2'b10 : 2'b11)),
            ((wr || ack_en) ? d : 16'hFFFF)};
  endfunction

  function automatic logic [31:0] user_word(input bit go, input bit wr, input bit ack,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {go, wr, ack, 3'b000, rg, phy, d};
  endfunction

  task automatic arm_phy(input bit wr, input logic [15:0] d, input bit ack_en);
    phy_rd = !wr; phy_ack_en = ack_en; phy_rdata = d;
    cap = '0; phy_idx = 0; oe_bad = 0; fall_bad = 0;
  endtask

  task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
      input logic [15:0] d, input bit ack_en, input int div);
    logic [31:0] v;
    logic [31:0] expw;
    arm_phy(wr, d, ack_en);
    wr_reg(1, user_word(1'b1, wr, 1'b1, phy, rg, wr ? d : 16'h0));
    rd_reg(0, v);
    check(v[31] == 1'b0, "R10 idle low while busy", 64'(v[31]), 64'd0);
    rd_reg(1, v);
    check(v[31] == 1'b1, "R7 busy set after launch", 64'(v[31]), 64'd1);
    wait_idle();
    repeat (4) @(negedge clk);
    check(cap == exp_frame(wr, phy, rg, d, ack_en), wr ? "R4 write frame bits" : "R5 read frame bits",
          cap, exp_frame(wr, phy, rg, d, ack_en));
    check(phy_idx == 64, "R7 rising edge count", 64'(phy_idx), 64'd64);
    check(oe_bad == 0, "R5 output enable per bit", 64'(oe_bad), 64'd0);
    check(fall_bad == 0, "R6 data changes on mdc fall", 64'(fall_bad), 64'd0);
    check((rise1 - rise0) == 2*(div+1), "R3 mdc period", 64'(rise1 - rise0), 64'(2*(div+1)));
    rd_reg(1, v);
    if (wr) expw = user_word(1'b0, 1'b1, 1'b0, phy, rg, d);
    else    expw = user_word(1'b0, 1'b0, ack_en, phy, rg, ack_en ? d : v[15:0]);
    check(v == expw, "R8 R12 transaction word after frame", 64'(v), 64'(expw));
    rd_reg(0, v);
    check(v[31] == 1'b1, "R10 idle after frame", 64'(v[31]), 64'd1);
    check(mdc == 1'b0, "R3 mdc low when idle", 64'(mdc), 64'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_reg(0, v);
    check(v == {1'b1, 1'b0, 22'd0, DIV_RESET}, "R1 control reset", 64'(v), 64'({1'b1, 1'b0, 22'd0, DIV_RESET}));
    rd_reg(1, v);
    check(v == 32'd0, "R1 transaction reset", 64'(v), 64'd0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins reset", 64'({mdc, mdio_oe}), 64'd0);

    wr_reg(0, 32'hC000_0003);
    rd_reg(0, v);
    check(v == 32'hC000_0003, "R2 control write, idle read-only", 64'(v), 64'hC000_0003);
    rd_reg(2, v);
    check(v == 32'd0, "R2 unmapped index reads zero", 64'(v), 64'd0);

    for (int div = 0; div < 4; div++) begin
      wr_reg(0, {1'b0, 1'b1, 22'd0, 8'(div)});
      run_frame(1'b1, 5'h15, 5'h0A, 16'hA5C3, 1'b0, div);
      run_frame(1'b0, 5'h01, 5'h1F, 16'h8001, 1'b1, div);
      run_frame(1'b0, 5'h1E, 5'h02, 16'h1234, 1'b0, div);
      run_frame(1'b1, 5'h00, 5'h11, 16'h0000, 1'b0, div);
      run_frame(1'b0, 5'h0C, 5'h05, 16'hFFFF, 1'b1, div);
    end

    // R9: write during a running frame is ignored
    wr_reg(0, 32'h4000_0001);
    arm_phy(1'b1, 16'h3C3C, 1'b0);
    wr_reg(1, user_word(1'b1, 1'b1, 1'b0, 5'h07, 5'h09, 16'h3C3C));
    wr_reg(1, user_word(1'b1, 1'b0, 1'b0, 5'h18, 5'h14, 16'hDEAD));
    wait_idle();
    repeat (40) @(negedge clk);
    check(cap == exp_frame(1'b1, 5'h07, 5'h09, 16'h3C3C, 1'b0), "R9 frame unchanged by busy write",
          cap, exp_frame(1'b1, 5'h07, 5'h09, 16'h3C3C, 1'b0));
    check(phy_idx == 64, "R9 no second frame", 64'(phy_idx), 64'd64);
    rd_reg(1, v);
    check(v == user_word(1'b0, 1'b1, 1'b0, 5'h07, 5'h09, 16'h3C3C), "R9 fields unchanged",
          64'(v), 64'(user_word(1'b0, 1'b1, 1'b0, 5'h07, 5'h09, 16'h3C3C)));

    // R11: frame waits while enable is clear
    wr_reg(0, 32'h0000_0001);
    arm_phy(1'b0, 16'h6A59, 1'b1);
    wr_reg(1, user_word(1'b1, 1'b0, 1'b0, 5'h03, 5'h04, 16'h0));
    repeat (50) @(negedge clk);
    check(phy_idx == 0 && mdc == 1'b0, "R11 no mdc edges while disabled", 64'(phy_idx), 64'd0);
    rd_reg(1, v);
    check(v[31] == 1'b1, "R11 still busy while disabled", 64'(v[31]), 64'd1);
    wr_reg(0, 32'h4000_0001);
    wait_idle();
    repeat (4) @(negedge clk);
    check(cap == exp_frame(1'b0, 5'h03, 5'h04, 16'h6A59, 1'b1), "R11 frame completes after enable",
          cap, exp_frame(1'b0, 5'h03, 5'h04, 16'h6A59, 1'b1));
    rd_reg(1, v);
    check(v == user_word(1'b0, 1'b0, 1'b1, 5'h03, 5'h04, 16'h6A59), "R8 read data after resume",
          64'(v), 64'(user_word(1'b0, 1'b0, 1'b1, 5'h03, 5'h04, 16'h6A59)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule